// File: doc/BRIEF.md
# Flat-Panel Scan Timing Generator

This block produces the raster timing for a flat LCD panel. It divides the system clock into a pixel clock, walks a horizontal position through a line and a vertical position through a frame, and drives horizontal sync, vertical sync, an output-enable strobe for active pixels, and the current pixel and line indices. A pixel-data fetch unit or a panel driver uses these indices and strobes to place data on the panel pins.

Software sets every timing quantity through plain configuration inputs. The active width is stored as its pixel count less sixteen, and the active height as its line count less one. Sync widths are stored as their length less one. Margins are stored unbiased. The polarity of each sync, of the output enable and of the pixel clock is set by a single bit. The block takes a new setting only when a frame ends, so a frame in progress is never disturbed. In dual-scan mode the programmed height is half the panel height. The block then also reports the matching line index of the lower half, because both halves are scanned at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, the internal settings are zero: hsync_o=1, vsync_o=1, oe_o=0, pclk_o=0, pix_ce_o=0, and px_o, line_o and line_lo_o are 0. The inputs are captured at the first clock edge after reset is released, and the frame starts from that edge.
- R2: The internal pixel clock toggles once every cfg_div_i+1 clocks, so one pixel lasts P=2*(cfg_div_i+1) clocks. pix_ce_o is high for exactly one clock, the last clock of each pixel.
- R3: pclk_o is the internal pixel clock, starting low after each frame start, and is inverted when cfg_pclk_fall_i=1.
- R4: Each line runs in this order: sync for cfg_hsync_w_i+1 pixels, begin delay for cfg_hbeg_i pixels, active for cfg_width_i+16 pixels, end delay for cfg_hend_i pixels.
- R5: Each frame runs in this order, counted in lines: sync for cfg_vsync_w_i+1 lines, begin delay for cfg_vbeg_i lines, active for cfg_height_i+1 lines, end delay for cfg_vend_i lines.
- R6: hsync_o is 1 during the horizontal sync phase when cfg_hs_low_i=0, and 0 during that phase when cfg_hs_low_i=1. vsync_o follows the same rule with cfg_vs_low_i.
- R7: The output enable is asserted when both the horizontal and the vertical positions are active. oe_o is 1 when asserted if cfg_oe_low_i=0, and 0 when asserted if cfg_oe_low_i=1.
- R8: px_o gives the pixel index within the active pixels of the line (0 to width-1) and is 0 outside them. line_o gives the line index within the active lines and is 0 outside them.
- R9: With cfg_dual_i=1, line_lo_o equals line_o plus the programmed height (cfg_height_i+1) during active lines, and is 0 otherwise. With cfg_dual_i=0 it is always 0.
- R10: A change to any configuration input while a frame is running has no effect on any output until that frame ends. All inputs are then captured together.
- R11: A vertical begin or end delay of zero removes that phase from the frame entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_width_i | input | 10 | Active pixels per line minus 16 |
| cfg_hsync_w_i | input | 6 | Horizontal sync width minus 1 |
| cfg_hbeg_i | input | 8 | Pixels between sync and active area |
| cfg_hend_i | input | 8 | Pixels after the active area |
| cfg_height_i | input | 10 | Active lines per frame minus 1 |
| cfg_vsync_w_i | input | 6 | Vertical sync width minus 1, in lines |
| cfg_vbeg_i | input | 8 | Lines between vertical sync and active lines |
| cfg_vend_i | input | 8 | Lines after the active lines |
| cfg_div_i | input | 8 | Pixel clock divider; half period is this plus one clocks |
| cfg_hs_low_i | input | 1 | Horizontal sync active low |
| cfg_vs_low_i | input | 1 | Vertical sync active low |
| cfg_pclk_fall_i | input | 1 | Invert the pixel clock output |
| cfg_oe_low_i | input | 1 | Output enable active low |
| cfg_dual_i | input | 1 | Dual-scan panel mode |
| pclk_o | output | 1 | Pixel clock |
| pix_ce_o | output | 1 | One-clock strobe in the last clock of each pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| oe_o | output | 1 | Output enable for active pixels |
| px_o | output | 11 | Active pixel index |
| line_o | output | 11 | Active line index (upper half in dual scan) |
| line_lo_o | output | 11 | Lower-half line index in dual scan |

## Verification
The end of a frame and a change of configuration can fall in the same clock. At that edge the last pixel step wraps both counters, the divider restarts and the new settings are captured, all at once. The bench changes the inputs at random times, often in the middle of a frame and sometimes in the clock just before a frame ends. A bench model that only takes the new inputs at its own computed frame boundary then predicts every output in every clock. Any mismatch in the first pixels of the next frame therefore shows that the capture came early or late.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int SIZE_W     = 10;
    localparam int SYNC_W     = 6;
    localparam int MARG_W     = 8;
    localparam int DIV_W      = 8;
    localparam int CNT_W      = SIZE_W + 1;
    localparam int WIDTH_BIAS = 16;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BEGIN  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_END    = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SIZE_W-1:0] width;
        logic [SYNC_W-1:0] hsw;
        logic [MARG_W-1:0] hbeg;
        logic [MARG_W-1:0] hend;
        logic [SIZE_W-1:0] height;
        logic [SYNC_W-1:0] vsw;
        logic [MARG_W-1:0] vbeg;
        logic [MARG_W-1:0] vend;
        logic [DIV_W-1:0]  div;
        logic              hs_low;
        logic              vs_low;
        logic              pclk_fall;
        logic              oe_low;
        logic              dual;
    } cfg_t;
endpackage

// File: rtl/lcdt_pclk.sv
module lcdt_pclk #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hold_i,
    input  logic [DW-1:0] div_i,
    output logic          pclk_o,
    output logic          step_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          pclk;
    } st_t;

    st_t  st_q, st_d;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = !hold_i && (st_q.cnt == div_i);
        if (hold_i) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt  = '0;
            st_d.pclk = ~st_q.pclk;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pclk_o = st_q.pclk;
    assign step_o = tick & st_q.pclk;

    a_r2_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= div_i);

    a_r2_step_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    input  logic [CW-1:0] len_sync_i,
    input  logic [CW-1:0] len_beg_i,
    input  logic [CW-1:0] len_act_i,
    input  logic [CW-1:0] len_end_i,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_q, st_d;
    logic [CW-1:0] cur_len;
    logic          last;
    logic          wrap;

    always_comb begin
        case (st_q.ph)
            PH_SYNC:   cur_len = len_sync_i;
            PH_BEGIN:  cur_len = len_beg_i;
            PH_ACTIVE: cur_len = len_act_i;
            default:   cur_len = len_end_i;
        endcase
        last = (st_q.cnt == cur_len - CW'(1));
        wrap = step_i && last &&
               ((st_q.ph == PH_END) ||
                ((st_q.ph == PH_ACTIVE) && (len_end_i == '0)));
        st_d = st_q;
        if (step_i) begin
            if (last) begin
                st_d.cnt = '0;
                case (st_q.ph)
                    PH_SYNC:   st_d.ph = (len_beg_i != '0) ? PH_BEGIN : PH_ACTIVE;
                    PH_BEGIN:  st_d.ph = PH_ACTIVE;
                    PH_ACTIVE: st_d.ph = (len_end_i != '0) ? PH_END : PH_SYNC;
                    default:   st_d.ph = PH_SYNC;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{ph: PH_SYNC, cnt: '0};
        else         st_q <= st_d;
    end

    assign phase_o = st_q.ph;
    assign cnt_o   = st_q.cnt;
    assign wrap_o  = wrap;

    a_r4_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(st_q));

    a_r5_count_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < cur_len);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SIZE_W-1:0] cfg_width_i,
    input  logic [SYNC_W-1:0] cfg_hsync_w_i,
    input  logic [MARG_W-1:0] cfg_hbeg_i,
    input  logic [MARG_W-1:0] cfg_hend_i,
    input  logic [SIZE_W-1:0] cfg_height_i,
    input  logic [SYNC_W-1:0] cfg_vsync_w_i,
    input  logic [MARG_W-1:0] cfg_vbeg_i,
    input  logic [MARG_W-1:0] cfg_vend_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              cfg_hs_low_i,
    input  logic              cfg_vs_low_i,
    input  logic              cfg_pclk_fall_i,
    input  logic              cfg_oe_low_i,
    input  logic              cfg_dual_i,
    output logic              pclk_o,
    output logic              pix_ce_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              oe_o,
    output logic [CNT_W-1:0]  px_o,
    output logic [CNT_W-1:0]  line_o,
    output logic [CNT_W-1:0]  line_lo_o
);
    typedef struct packed {
        logic fresh;
        cfg_t sh;
    } st_t;

    st_t  st_q, st_d;
    cfg_t cfg_in;
    logic load;

    logic             pclk_int, pix_step;
    phase_e           h_ph, v_ph;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_wrap, v_wrap;
    logic [CNT_W-1:0] h_len_sync, h_len_beg, h_len_act, h_len_end;
    logic [CNT_W-1:0] v_len_sync, v_len_beg, v_len_act, v_len_end;

    assign cfg_in = '{width: cfg_width_i, hsw: cfg_hsync_w_i, hbeg: cfg_hbeg_i,
                      hend: cfg_hend_i, height: cfg_height_i, vsw: cfg_vsync_w_i,
                      vbeg: cfg_vbeg_i, vend: cfg_vend_i, div: cfg_div_i,
                      hs_low: cfg_hs_low_i, vs_low: cfg_vs_low_i,
                      pclk_fall: cfg_pclk_fall_i, oe_low: cfg_oe_low_i,
                      dual: cfg_dual_i};

    // Settings are captured once after reset and then only when a frame wraps.
    always_comb begin
        st_d       = st_q;
        load       = st_q.fresh | v_wrap;
        st_d.fresh = 1'b0;
        if (load) st_d.sh = cfg_in;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{fresh: 1'b1, sh: '0};
        else         st_q <= st_d;
    end

    // Biased encodings expanded into phase lengths.
    always_comb begin
        h_len_sync = CNT_W'(st_q.sh.hsw) + CNT_W'(1);
        h_len_beg  = CNT_W'(st_q.sh.hbeg);
        h_len_act  = CNT_W'(st_q.sh.width) + CNT_W'(WIDTH_BIAS);
        h_len_end  = CNT_W'(st_q.sh.hend);
        v_len_sync = CNT_W'(st_q.sh.vsw) + CNT_W'(1);
        v_len_beg  = CNT_W'(st_q.sh.vbeg);
        v_len_act  = CNT_W'(st_q.sh.height) + CNT_W'(1);
        v_len_end  = CNT_W'(st_q.sh.vend);
    end

    lcdt_pclk #(.DW(DIV_W)) u_pclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (st_q.fresh),
        .div_i  (st_q.sh.div),
        .pclk_o (pclk_int),
        .step_o (pix_step)
    );

    lcdt_axis #(.CW(CNT_W)) u_haxis (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (pix_step),
        .len_sync_i (h_len_sync),
        .len_beg_i  (h_len_beg),
        .len_act_i  (h_len_act),
        .len_end_i  (h_len_end),
        .phase_o    (h_ph),
        .cnt_o      (h_cnt),
        .wrap_o     (h_wrap)
    );

    lcdt_axis #(.CW(CNT_W)) u_vaxis (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (h_wrap),
        .len_sync_i (v_len_sync),
        .len_beg_i  (v_len_beg),
        .len_act_i  (v_len_act),
        .len_end_i  (v_len_end),
        .phase_o    (v_ph),
        .cnt_o      (v_cnt),
        .wrap_o     (v_wrap)
    );

    logic h_act, v_act;
    always_comb begin
        h_act     = (h_ph == PH_ACTIVE);
        v_act     = (v_ph == PH_ACTIVE);
        pclk_o    = pclk_int ^ st_q.sh.pclk_fall;
        pix_ce_o  = pix_step;
        hsync_o   = (h_ph == PH_SYNC) ^ st_q.sh.hs_low;
        vsync_o   = (v_ph == PH_SYNC) ^ st_q.sh.vs_low;
        oe_o      = (h_act && v_act) ^ st_q.sh.oe_low;
        px_o      = h_act ? h_cnt : '0;
        line_o    = v_act ? v_cnt : '0;
        line_lo_o = (st_q.sh.dual && v_act) ? (v_cnt + v_len_act) : '0;
    end

    a_r10_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load |=> $stable(st_q.sh));

    a_r1_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.fresh |=> !st_q.fresh);
endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [9:0]  w, h;
    logic [5:0]  hsw, vsw;
    logic [7:0]  hb, he, vb, ve, dv;
    logic        hsl, vsl, fall, oel, dual;
    logic        pclk, pce, hs, vs, oe;
    logic [10:0] px, ln, lo;

    lcd_timing_gen uut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_width_i(w), .cfg_hsync_w_i(hsw), .cfg_hbeg_i(hb), .cfg_hend_i(he),
        .cfg_height_i(h), .cfg_vsync_w_i(vsw), .cfg_vbeg_i(vb), .cfg_vend_i(ve),
        .cfg_div_i(dv), .cfg_hs_low_i(hsl), .cfg_vs_low_i(vsl),
        .cfg_pclk_fall_i(fall), .cfg_oe_low_i(oel), .cfg_dual_i(dual),
        .pclk_o(pclk), .pix_ce_o(pce), .hsync_o(hs), .vsync_o(vs), .oe_o(oe),
        .px_o(px), .line_o(ln), .line_lo_o(lo)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int c_w, c_h, c_hsw, c_vsw, c_hb, c_he, c_vb, c_ve, c_div;
    int c_hsl, c_vsl, c_fall, c_oel, c_dual;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_cur();
        c_w = w; c_h = h; c_hsw = hsw; c_vsw = vsw; c_hb = hb; c_he = he;
        c_vb = vb; c_ve = ve; c_div = dv; c_hsl = hsl; c_vsl = vsl;
        c_fall = fall; c_oel = oel; c_dual = dual;
    endtask

    function automatic bit inputs_differ();
        return (c_w != w) || (c_h != h) || (c_hsw != hsw) || (c_vsw != vsw) ||
               (c_hb != hb) || (c_he != he) || (c_vb != vb) || (c_ve != ve) ||
               (c_div != dv);
    endfunction

    function automatic int frame_clocks();
        int l, f;
        l = c_hsw + 1 + c_hb + c_w + 16 + c_he;
        f = c_vsw + 1 + c_vb + c_h + 1 + c_ve;
        return l * f * 2 * (c_div + 1);
    endfunction

    task automatic set_inputs(int k);
        if (k == 0) begin
            w = 0; hsw = 0; hb = 1; he = 1; h = 0; vsw = 0; vb = 0; ve = 0;
            dv = 0; hsl = 1; vsl = 1; fall = 1; oel = 1; dual = 1;
        end else if (k == 1) begin
            w = 2; hsw = 3; hb = 4; he = 2; h = 4; vsw = 2; vb = 3; ve = 3;
            dv = 3; hsl = 0; vsl = 0; fall = 0; oel = 0; dual = 0;
        end else begin
            w = 10'($urandom % 4);  hsw = 6'($urandom % 4);
            hb = 8'(1 + $urandom % 4); he = 8'(1 + $urandom % 4);
            h = 10'($urandom % 6);  vsw = 6'($urandom % 3);
            vb = 8'($urandom % 4);  ve = 8'($urandom % 4);
            dv = 8'($urandom % 4);
            hsl = 1'($urandom); vsl = 1'($urandom); fall = 1'($urandom);
            oel = 1'($urandom); dual = 1'($urandom);
        end
    endtask

    task automatic check_all(int u);
        int p, pix, s, b, a, l, x, y, vs_n, vb_n, va, hsyn, hact, vsyn, vact;
        p = 2 * (c_div + 1);
        chk(c_fall != 0 ? "R3 pclk" : "R2 pclk", int'(pclk),
            ((u / (c_div + 1)) % 2) ^ c_fall);
        chk("R2 pix_ce", int'(pce), ((u + 1) % p == 0) ? 1 : 0);
        pix = u / p;
        s = c_hsw + 1; b = c_hb; a = c_w + 16;
        l = s + b + a + c_he;
        x = pix % l; y = pix / l;
        vs_n = c_vsw + 1; vb_n = c_vb; va = c_h + 1;
        hsyn = (x < s) ? 1 : 0;
        hact = (x >= s + b && x < s + b + a) ? 1 : 0;
        vsyn = (y < vs_n) ? 1 : 0;
        vact = (y >= vs_n + vb_n && y < vs_n + vb_n + va) ? 1 : 0;
        chk(c_hsl != 0 ? "R6 hsync" : "R4 hsync", int'(hs), hsyn ^ c_hsl);
        chk(c_vsl != 0 ? "R6 vsync" : ((c_vb == 0 || c_ve == 0) ? "R11 vsync" : "R5 vsync"),
            int'(vs), vsyn ^ c_vsl);
        chk("R7 oe", int'(oe), (hact & vact) ^ c_oel);
        chk(inputs_differ() ? "R10 px" : "R8 px", int'(px), hact ? x - s - b : 0);
        chk("R8 line", int'(ln), vact ? y - vs_n - vb_n : 0);
        chk("R9 line_lo", int'(lo), (c_dual != 0 && vact != 0) ? y - vs_n - vb_n + va : 0);
    endtask

    initial begin
        int base, next_change, k;
        void'($urandom(32'h5eed_1cd0));
        rst_n = 1'b0;
        set_inputs(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        chk("R1 hsync", int'(hs), 1);
        chk("R1 vsync", int'(vs), 1);
        chk("R1 oe", int'(oe), 0);
        chk("R1 pclk", int'(pclk), 0);
        chk("R1 pix_ce", int'(pce), 0);
        chk("R1 px", int'(px), 0);
        chk("R1 line_lo", int'(lo), 0);
        rst_n = 1'b1;
        @(posedge clk);
        load_cur();
        base = 0;
        k = 1;
        next_change = 3000;
        for (int t = 0; t < 120000; t++) begin
            @(negedge clk);
            if (t - base == frame_clocks()) begin
                base = t;
                load_cur();
            end
            check_all(t - base);
            if (t == next_change) begin
                set_inputs(k);
                k++;
                next_change = t + 1500 + int'($urandom % 3000);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule